// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block lets a host reach a separate 32-bit register space one word at a time through a small window of four 32-bit registers. The four registers hold a command, a target address, captured read data and write data. The host loads the address, and for a write also the data. It then writes a read or write request into the command register and polls that register until the completion flag appears. A read result is then taken from the read-data register. Writing zero to the command register returns the bridge to idle.

On the target side the bridge drives a single-word request bus with a valid/ready handshake. The request is held until the target answers with ready, which also carries the read data. Requests with an illegal address never reach the target, and a stalled target is cut off by an internal watchdog. In both cases the host still sees a completion, with zero read data, so host polling always ends well inside its own timeout.

Top module: `regwin_bridge`

## Requirements
- R1: The window sits at host byte address WIN_BASE (default 0x400). Its word-aligned offsets are 0x0 command, 0x4 target address, 0x8 read data and 0xC write data. Any access outside these four words, or not word aligned, writes nothing and reads zero. Host reads return data one clock after the read strobe.
- R2: Command bit 0 requests a read, bit 1 requests a write and bit 2 is the completion flag. A command write takes effect only when exactly one of bits 0 and 1 is set, and the value of bit 2 in the written word is ignored.
- R3: A target request starts only through a command write. In the clock after that write, t_valid is high, t_addr equals the low address bits, t_we is high for a write, and t_wdata equals the write-data register.
- R4: The request is held unchanged until t_ready. On t_ready the command reads back as the request bit plus bit 2 (5 for a read, 6 for a write), and a read captures t_rdata into the read-data register.
- R5: After completion, the command value and the read data stay unchanged, and no new request is issued, however often the host polls. They stay so until the host writes a command with bits 0 and 1 both zero; after that the command register reads exactly 0.
- R6: A command with both bits 0 and 1 set is ignored: the command stays 0 and no request is issued.
- R7: While a request is outstanding, host writes to the command, address and write-data registers are ignored. After completion, command writes other than the clear are ignored.
- R8: A target address of 0x1000 or above (TGT_SPAN), or one not aligned to 4, issues no request. It completes in the clock after the command write with bit 2 set and read data 0.
- R9: If t_ready has not arrived after WDOG_CYCLES cycles of t_valid, the request is dropped and completes with bit 2 set and read data 0. A t_ready in the final allowed cycle still completes normally.
- R10: Reset clears all four registers, drops any outstanding request and returns the bridge to idle.
- R11: The read-data register cannot be written by the host, and a normal write completion leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | HAW (12) | Host byte address within the feature region |
| h_wdata | input | DW (32) | Host write data |
| h_rdata | output | DW (32) | Host read data, valid the clock after h_rd |
| t_valid | output | 1 | Target request outstanding |
| t_we | output | 1 | Target request is a write |
| t_addr | output | TAW (12) | Target byte address |
| t_wdata | output | DW (32) | Target write data |
| t_ready | input | 1 | Target completes the request |
| t_rdata | input | DW (32) | Target read data, taken with t_ready |

## Verification
Two functions can fall in the same cycle: the target's ready and the watchdog expiry. The bench provokes this by sweeping the target response delay from one cycle up to two past the watchdog limit, so that ready lands before, exactly on, and after the expiry edge. Each case is judged at the ports. A delay up to and including the limit must yield the target's data, and any longer delay must yield zero read data. In every case the completion flag must be set and t_valid must be low.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_DONE = 2'd2
   } seq_st_e;

   localparam logic [1:0] IDX_CMD  = 2'd0;
   localparam logic [1:0] IDX_ADDR = 2'd1;
   localparam logic [1:0] IDX_RDAT = 2'd2;
   localparam logic [1:0] IDX_WDAT = 2'd3;

   localparam int CMD_RD_BIT  = 0;
   localparam int CMD_WR_BIT  = 1;
   localparam int CMD_ACK_BIT = 2;
   localparam int CMD_W       = 3;
endpackage

// File: rtl/regwin_csr.sv
module regwin_csr
   import regwin_pkg::*;
#(
   parameter int HAW      = 12,
   parameter int DW       = 32,
   parameter int WIN_BASE = 'h400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_wr,
   input  logic              h_rd,
   input  logic [HAW-1:0]    h_addr,
   input  logic [DW-1:0]     h_wdata,
   output logic [DW-1:0]     h_rdata,
   input  logic              lock,
   input  logic [CMD_W-1:0]  cmd_q,
   input  logic [DW-1:0]     rdat_q,
   output logic              cmd_we,
   output logic [1:0]        cmd_wbits,
   output logic [DW-1:0]     addr_q,
   output logic [DW-1:0]     wdat_q
);
   localparam logic [HAW-1:0] BASE_V = HAW'(WIN_BASE);

   logic       hit;
   logic [1:0] idx;
   logic [DW-1:0] rd_mux;

   // R1: window decode, word aligned only
   assign hit = (h_addr[HAW-1:4] == BASE_V[HAW-1:4]) && (h_addr[1:0] == 2'b00);
   assign idx = h_addr[3:2];

   assign cmd_we    = h_wr && hit && (idx == IDX_CMD);
   assign cmd_wbits = h_wdata[1:0];

   // R7: address and write data frozen while a request is outstanding
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         wdat_q <= '0;
      end else if (h_wr && hit && !lock) begin
         if (idx == IDX_ADDR) addr_q <= h_wdata;
         if (idx == IDX_WDAT) wdat_q <= h_wdata;
      end
   end

   always_comb begin
      case (idx)
         IDX_CMD:  rd_mux = {{(DW-CMD_W){1'b0}}, cmd_q};
         IDX_ADDR: rd_mux = addr_q;
         IDX_RDAT: rd_mux = rdat_q;
         default:  rd_mux = wdat_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    h_rdata <= '0;
      else if (h_rd) h_rdata <= hit ? rd_mux : '0;
   end
endmodule

// File: rtl/regwin_wdog.sv
module regwin_wdog #(
   parameter int WDOG_CYCLES = 65536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CW = $clog2(WDOG_CYCLES + 1);
   localparam logic [CW-1:0] LIM = CW'(WDOG_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else                cnt <= cnt + 1'b1;
   end

   // R9: fires in the last allowed cycle of an outstanding request
   assign expire = run && (cnt == LIM);
endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
   import regwin_pkg::*;
#(
   parameter int DW          = 32,
   parameter int TAW         = 12,
   parameter int WDOG_CYCLES = 65536
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [1:0]        cmd_wbits,
   input  logic [DW-1:0]     addr_q,
   input  logic [DW-1:0]     wdat_q,
   output logic [CMD_W-1:0]  cmd_q,
   output logic [DW-1:0]     rdat_q,
   output logic              t_valid,
   output logic              t_we,
   output logic [TAW-1:0]    t_addr,
   output logic [DW-1:0]     t_wdata,
   input  logic              t_ready,
   input  logic [DW-1:0]     t_rdata
);
   seq_st_e st;
   logic    start_ok;
   logic    addr_bad;
   logic    wd_expire;

   // R2, R6: exactly one request bit must be set
   assign start_ok = cmd_wbits[0] ^ cmd_wbits[1];
   // R8: out of span or misaligned
   assign addr_bad = (|addr_q[DW-1:TAW]) || (|addr_q[1:0]);

   regwin_wdog #(.WDOG_CYCLES(WDOG_CYCLES)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (st == ST_BUSY),
      .expire (wd_expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cmd_q  <= '0;
         rdat_q <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (cmd_we && start_ok) begin
                  cmd_q <= {addr_bad, cmd_wbits};
                  if (addr_bad) begin
                     rdat_q <= '0;
                     st     <= ST_DONE;
                  end else begin
                     st <= ST_BUSY;
                  end
               end
            end
            ST_BUSY: begin
               // target ready wins over a same-cycle watchdog expiry
               if (t_ready) begin
                  cmd_q[CMD_ACK_BIT] <= 1'b1;
                  if (cmd_q[CMD_RD_BIT]) rdat_q <= t_rdata;
                  st <= ST_DONE;
               end else if (wd_expire) begin
                  cmd_q[CMD_ACK_BIT] <= 1'b1;
                  rdat_q <= '0;
                  st     <= ST_DONE;
               end
            end
            ST_DONE: begin
               if (cmd_we && (cmd_wbits == 2'b00)) begin
                  cmd_q <= '0;
                  st    <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign t_valid = (st == ST_BUSY);
   assign t_we    = cmd_q[CMD_WR_BIT];
   assign t_addr  = addr_q[TAW-1:0];
   assign t_wdata = wdat_q;
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
   import regwin_pkg::*;
#(
   parameter int DW          = 32,
   parameter int HAW         = 12,
   parameter int WIN_BASE    = 'h400,
   parameter int TGT_SPAN    = 4096,
   parameter int WDOG_CYCLES = 65536,
   localparam int TAW        = $clog2(TGT_SPAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_wr,
   input  logic              h_rd,
   input  logic [HAW-1:0]    h_addr,
   input  logic [DW-1:0]     h_wdata,
   output logic [DW-1:0]     h_rdata,
   output logic              t_valid,
   output logic              t_we,
   output logic [TAW-1:0]    t_addr,
   output logic [DW-1:0]     t_wdata,
   input  logic              t_ready,
   input  logic [DW-1:0]     t_rdata
);
   generate
      if (TGT_SPAN != (1 << TAW)) begin : g_span_chk
         $error("TGT_SPAN must be a power of two");
      end
      if (TAW < 3 || DW <= TAW) begin : g_width_chk
         $error("DW must exceed the target address width, which must be at least 3");
      end
      if ((WIN_BASE % 16) != 0 || WIN_BASE >= (1 << HAW)) begin : g_base_chk
         $error("WIN_BASE must be 16-byte aligned and inside the host address range");
      end
      if (WDOG_CYCLES < 2) begin : g_wdog_chk
         $error("WDOG_CYCLES must be at least 2");
      end
   endgenerate

   logic [CMD_W-1:0] cmd_q;
   logic [DW-1:0]    rdat_q;
   logic             cmd_we;
   logic [1:0]       cmd_wbits;
   logic [DW-1:0]    addr_q;
   logic [DW-1:0]    wdat_q;

   regwin_csr #(.HAW(HAW), .DW(DW), .WIN_BASE(WIN_BASE)) u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .h_wr      (h_wr),
      .h_rd      (h_rd),
      .h_addr    (h_addr),
      .h_wdata   (h_wdata),
      .h_rdata   (h_rdata),
      .lock      (t_valid),
      .cmd_q     (cmd_q),
      .rdat_q    (rdat_q),
      .cmd_we    (cmd_we),
      .cmd_wbits (cmd_wbits),
      .addr_q    (addr_q),
      .wdat_q    (wdat_q)
   );

   regwin_seq #(.DW(DW), .TAW(TAW), .WDOG_CYCLES(WDOG_CYCLES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (cmd_we),
      .cmd_wbits (cmd_wbits),
      .addr_q    (addr_q),
      .wdat_q    (wdat_q),
      .cmd_q     (cmd_q),
      .rdat_q    (rdat_q),
      .t_valid   (t_valid),
      .t_we      (t_we),
      .t_addr    (t_addr),
      .t_wdata   (t_wdata),
      .t_ready   (t_ready),
      .t_rdata   (t_rdata)
   );
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
   parameter int DW          = 32,
   parameter int TAW         = 12,
   parameter int WDOG_CYCLES = 65536
) (
   input logic           clk,
   input logic           rst_n,
   input logic           t_valid,
   input logic           t_ready,
   input logic           t_we,
   input logic [TAW-1:0] t_addr,
   input logic [DW-1:0]  t_wdata,
   input logic [2:0]     cmd_q,
   input logic [DW-1:0]  rdat_q,
   input logic           cmd_we,
   input logic [1:0]     cmd_wbits
);
   int unsigned busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !t_valid) busy_cnt <= 0;
      else                    busy_cnt <= busy_cnt + 1;
   end

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_valid && !t_ready && (busy_cnt < WDOG_CYCLES - 1)
      |=> t_valid && $stable(t_addr) && $stable(t_we) && $stable(t_wdata));

   // R9
   wdog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_valid |-> (busy_cnt < WDOG_CYCLES));

   // R5
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_q[2] && !(cmd_we && (cmd_wbits == 2'b00))
      |=> cmd_q[2] && $stable(cmd_q) && $stable(rdat_q) && !t_valid);

   // R5
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_q[2] && cmd_we && (cmd_wbits == 2'b00) |=> (cmd_q == 3'b000));

   // R6
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_q[1:0]));

   // R3
   req_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_valid |-> (cmd_q[1:0] != 2'b00) && !cmd_q[2]);
endmodule

bind regwin_bridge regwin_chk #(.DW(DW), .TAW(TAW), .WDOG_CYCLES(WDOG_CYCLES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .t_valid   (t_valid),
   .t_ready   (t_ready),
   .t_we      (t_we),
   .t_addr    (t_addr),
   .t_wdata   (t_wdata),
   .cmd_q     (cmd_q),
   .rdat_q    (rdat_q),
   .cmd_we    (cmd_we),
   .cmd_wbits (cmd_wbits)
);

// File: tb/regwin_bridge_tb.sv
module regwin_bridge_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W    = 8;
   localparam int DW   = 32;
   localparam int HAW  = 12;
   localparam int TAW  = 12;

   localparam logic [HAW-1:0] A_CMD  = 12'h400;
   localparam logic [HAW-1:0] A_ADDR = 12'h404;
   localparam logic [HAW-1:0] A_RDAT = 12'h408;
   localparam logic [HAW-1:0] A_WDAT = 12'h40C;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           h_wr = 1'b0;
   logic           h_rd = 1'b0;
   logic [HAW-1:0] h_addr = '0;
   logic [DW-1:0]  h_wdata = '0;
   logic [DW-1:0]  h_rdata;
   logic           t_valid;
   logic           t_we;
   logic [TAW-1:0] t_addr;
   logic [DW-1:0]  t_wdata;
   logic           t_ready = 1'b0;
   logic [DW-1:0]  t_rdata = '0;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [DW-1:0] exp_rdat = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regwin_bridge #(.DW(DW), .HAW(HAW), .WIN_BASE('h400), .TGT_SPAN(4096), .WDOG_CYCLES(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .t_valid(t_valid), .t_we(t_we),
      .t_addr(t_addr), .t_wdata(t_wdata), .t_ready(t_ready), .t_rdata(t_rdata)
   );

   function automatic logic [DW-1:0] tgt_val(input logic [DW-1:0] a);
      return 32'hC300_005A ^ (a * 32'h0001_0001);
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic hwr(input logic [HAW-1:0] a, input logic [DW-1:0] d);
      h_wr = 1'b1; h_addr = a; h_wdata = d;
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic hrd(input logic [HAW-1:0] a, output logic [DW-1:0] v);
      h_rd = 1'b1; h_addr = a;
      @(negedge clk);
      h_rd = 1'b0;
      v = h_rdata;
   endtask

   // one full transaction; d = target delay in cycles, 0 = never answers
   task automatic txn(input bit is_rd, input logic [DW-1:0] a, input logic [DW-1:0] wd, input int d);
      logic [DW-1:0] v;
      bit good, ok;
      string tag;
      good = (a < 32'h1000) && (a[1:0] == 2'b00);
      ok   = good && (d >= 1) && (d <= W);
      tag  = !good ? "R8" : (ok ? "R4" : "R9");
      hwr(A_WDAT, wd);
      hwr(A_ADDR, a);
      hwr(A_CMD, is_rd ? 32'd1 : 32'd2);
      chk(good ? "R3 request issued" : "R8 no request", {31'b0, t_valid}, {31'b0, good});
      if (good) begin
         chk("R3 t_we", {31'b0, t_we}, {31'b0, !is_rd});
         chk("R3 t_addr", {20'b0, t_addr}, {20'b0, a[11:0]});
         if (!is_rd) chk("R3 t_wdata", t_wdata, wd);
      end
      if (d > 0) begin
         repeat (d - 1) @(negedge clk);
         t_ready = 1'b1; t_rdata = tgt_val(a);
         @(negedge clk);
         t_ready = 1'b0; t_rdata = '0;
      end else begin
         repeat (W + 1) @(negedge clk);
      end
      if (!ok) exp_rdat = '0;
      else if (is_rd) exp_rdat = tgt_val(a);
      hrd(A_CMD, v);
      chk({tag, " completion"}, v, is_rd ? 32'd5 : 32'd6);
      hrd(A_CMD, v);
      chk("R5 poll again", v, is_rd ? 32'd5 : 32'd6);
      chk("R5 no retrigger", {31'b0, t_valid}, 32'd0);
      hrd(A_RDAT, v);
      chk({tag, " R11 read data"}, v, exp_rdat);
      hwr(A_CMD, 32'd0);
      hrd(A_CMD, v);
      chk("R5 cleared", v, 32'd0);
   endtask

   initial begin
      logic [DW-1:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      hrd(A_CMD, v);  chk("R10 cmd", v, 0);
      hrd(A_ADDR, v); chk("R10 addr", v, 0);
      hrd(A_RDAT, v); chk("R10 rdat", v, 0);
      hrd(A_WDAT, v); chk("R10 wdat", v, 0);
      chk("R10 idle", {31'b0, t_valid}, 0);

      // R1 decode
      hwr(A_ADDR, 32'h10); hwr(A_WDAT, 32'hCAFE_F00D);
      hwr(12'h004, 32'h1111); hwr(12'h414, 32'h2222); hwr(12'h406, 32'h3333); hwr(12'h3FC, 32'h4444);
      hrd(A_ADDR, v); chk("R1 addr kept", v, 32'h10);
      hrd(A_WDAT, v); chk("R1 wdat kept", v, 32'hCAFE_F00D);
      hrd(12'h004, v); chk("R1 outside reads 0", v, 0);
      hrd(12'h40D, v); chk("R1 misaligned reads 0", v, 0);
      // R11 read data not writable
      hwr(A_RDAT, 32'hDEAD_BEEF);
      hrd(A_RDAT, v); chk("R11 rdat read only", v, 0);

      // R2 and R6: illegal command words
      hwr(A_CMD, 32'd3);
      chk("R6 no request", {31'b0, t_valid}, 0);
      hrd(A_CMD, v); chk("R6 cmd stays 0", v, 0);
      hwr(A_CMD, 32'd7);
      hrd(A_CMD, v); chk("R6 both bits with flag", v, 0);
      hwr(A_CMD, 32'd4);
      chk("R2 flag alone no request", {31'b0, t_valid}, 0);
      hrd(A_CMD, v); chk("R2 flag alone ignored", v, 0);

      // sweep delay across watchdog boundary, both directions (R4, R9)
      for (int d = 1; d <= W + 2; d++) begin
         for (int rw = 0; rw < 2; rw++) begin
            txn(rw[0], (d * 32'h1F4 + rw * 32'h88) & 32'hFFC, 32'h5000_0000 + d * 16 + rw, d);
         end
      end
      txn(1'b1, 32'h0FFC, 32'h0, 0);
      txn(1'b0, 32'h0800, 32'h1234_5678, 0);

      // R8 illegal target addresses
      txn(1'b1, 32'h0000_1000, 32'h0, 3);
      txn(1'b1, 32'hFFFF_FFFC, 32'h0, 3);
      txn(1'b0, 32'h0000_0002, 32'h77, 3);
      txn(1'b1, 32'h0000_0FFF, 32'h0, 3);
      txn(1'b1, 32'h0000_0040, 32'h0, 2);   // refill read data
      txn(1'b0, 32'h0000_0003, 32'h99, 1);

      // R7 writes during an outstanding request are ignored
      hwr(A_ADDR, 32'h100);
      hwr(A_CMD, 32'd1);
      hwr(A_ADDR, 32'h200);
      hwr(A_WDAT, 32'hABCD_0000);
      hwr(A_CMD, 32'd2);
      hrd(A_CMD, v); chk("R7 cmd unchanged while busy", v, 32'd1);
      chk("R7 t_addr held", {20'b0, t_addr}, 32'h100);
      chk("R7 t_we held", {31'b0, t_we}, 0);
      t_ready = 1'b1; t_rdata = tgt_val(32'h100);
      @(negedge clk);
      t_ready = 1'b0; t_rdata = '0;
      hrd(A_RDAT, v); chk("R4 read data", v, tgt_val(32'h100));
      hwr(A_CMD, 32'd1);
      hrd(A_CMD, v); chk("R7 non-clear in done ignored", v, 32'd5);
      hwr(A_CMD, 32'd0);
      hrd(A_ADDR, v); chk("R7 addr write blocked", v, 32'h100);

      // R10 reset mid-request
      hwr(A_CMD, 32'd1);
      chk("R10 request before reset", {31'b0, t_valid}, 1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R10 request dropped", {31'b0, t_valid}, 0);
      hrd(A_CMD, v);  chk("R10 cmd cleared", v, 0);
      hrd(A_ADDR, v); chk("R10 addr cleared", v, 0);
      hrd(A_RDAT, v); chk("R10 rdat cleared", v, 0);

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL all-R bench watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule